// File: doc/BRIEF.md
# Strobe-Triggered Reset Stretcher

This block produces the internal reset pulses for a two-channel serial controller. A hardware reset is signalled on the host bus by driving the active-low read and write strobes low together, which is otherwise an illegal combination. Software resets arrive as a 2-bit command field written to the master control register. For each request the block drives a global reset, two per-channel resets and a flag for registers that only a hardware reset may clear. It then holds the reset on for a fixed number of clock cycles after the request ends.

While any reset is on, an access-block flag tells the bus interface to ignore all reads and writes. A request that arrives during a stretch starts the count again. The new scope is merged with the one in progress, so a channel reset can widen into a full reset, but a reset never narrows. The strobes are asynchronous to the peripheral clock and pass through a two-stage synchronizer first. The command field is already synchronous and is sampled on the clock edge where its write enable is high.

Top module: `reset_stretch_ctrl`

## Requirements
- R1: When both `rd_n` and `wr_n` are low, `glb_rst`, `chan_a_rst`, `chan_b_rst`, `hw_rst` and `access_block` all go high. They are visible after the 3rd rising edge that follows the strobes going low, which is two synchronizer stages plus one timer register, and they stay high for as long as both strobes stay low.
- R2: After the both-low condition ends, all five outputs stay high through the 5th rising edge. They clear on the 6th rising edge, which is 4 cycles after the synchronized release.
- R3: A single low strobe, with the other strobe high, causes no reset. All outputs stay low.
- R4: `access_block` is high whenever any reset output is high. It clears on the same edge as the last reset output.
- R5: A command is sampled on a rising edge where `cmd_wr` is 1. The codes of `cmd_field[1:0]` are: 00 no action, 01 channel B reset, 10 channel A reset, 11 full reset. The resulting outputs are high after that edge and stay high for 4 edges in total. They clear on the 5th edge.
- R6: A channel reset command (01 or 10) raises only that channel's reset and `access_block`. `glb_rst` and the other channel's reset stay low.
- R7: The full software reset (11) raises `glb_rst`, both channel resets and `access_block`, and it keeps `hw_rst` low. This lets the other master register bits written along with the command keep their new values.
- R8: `hw_rst` is high only during a reset that the strobes started.
- R9: A new request during a stretch reloads the count, so the stretch ends 4 edges after the edge that accepted the newest request.
- R10: A request during a stretch is merged with the reset in progress. A full command widens a channel reset to a full reset. A channel A command during a channel B reset gives both channel resets with `glb_rst` low.
- R11: If the synchronized both-low condition and a command are seen on the same edge, the hardware reset wins and `hw_rst` is set.
- R12: The synchronous reset `rst` clears the synchronizer and the timer, and all outputs are low on the next edge.
- R13: A command of 00 with `cmd_wr` high has no effect. All outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high block reset |
| rd_n | input | 1 | Bus read strobe, active low, asynchronous |
| wr_n | input | 1 | Bus write strobe, active low, asynchronous |
| cmd_wr | input | 1 | Master control register write enable for the command field |
| cmd_field | input | 2 | Reset command code (00 none, 01 ch B, 10 ch A, 11 full) |
| glb_rst | output | 1 | Full reset of the controller |
| chan_a_rst | output | 1 | Channel A reset |
| chan_b_rst | output | 1 | Channel B reset |
| hw_rst | output | 1 | Reset started by the strobes; clears master-register-only bits |
| access_block | output | 1 | Bus accesses must be ignored |

## Verification
A software command and a newly synchronized hardware request can reach the stretch timer on the same edge. A software command can also arrive while another reset's stretch is still running. The first case is provoked by pulling both strobes low and writing a channel A command just as the second synchronizer stage rises. The result must show the hardware scope, with `hw_rst` set, and the usual 6-edge release. The second case is provoked by channel commands and a full command written partway through a stretch. The result is judged by the merged scope and by the deassertion edge, counted from the newest request.

// File: rtl/rst_stretch_pkg.sv
package rst_stretch_pkg;

    typedef enum logic [1:0] {
        CMD_NONE    = 2'b00,
        CMD_RST_B   = 2'b01,
        CMD_RST_A   = 2'b10,
        CMD_RST_ALL = 2'b11
    } rst_cmd_e;

    typedef struct packed {
        logic hw;
        logic full;
        logic a;
        logic b;
    } rst_scope_t;

    localparam rst_scope_t SCOPE_NONE = '{hw: 1'b0, full: 1'b0, a: 1'b0, b: 1'b0};
    localparam rst_scope_t SCOPE_HW   = '{hw: 1'b1, full: 1'b1, a: 1'b1, b: 1'b1};

    function automatic rst_scope_t scope_of_cmd(rst_cmd_e cmd);
        rst_scope_t s;
        s = SCOPE_NONE;
        unique case (cmd)
            CMD_RST_B:   s.b = 1'b1;
            CMD_RST_A:   s.a = 1'b1;
            CMD_RST_ALL: begin
                s.full = 1'b1;
                s.a    = 1'b1;
                s.b    = 1'b1;
            end
            default:     s = SCOPE_NONE;
        endcase
        return s;
    endfunction

    function automatic logic scope_any(rst_scope_t s);
        return s.full | s.a | s.b;
    endfunction

    function automatic rst_scope_t scope_merge(rst_scope_t x, rst_scope_t y);
        return rst_scope_t'(x | y);
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rd_n,
    input  logic wr_n,
    output logic bus_low
);
    logic [STAGES-1:0] stg_q;
    logic              both_low;

    assign both_low = ~rd_n & ~wr_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= both_low;
            for (int i = 1; i < STAGES; i++) begin
                stg_q[i] <= stg_q[i-1];
            end
        end
    end

    assign bus_low = stg_q[STAGES-1];

    // R1
    sync_path_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_low) |-> $past(stg_q[STAGES-2]));

endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
    import rst_stretch_pkg::*;
(
    input  logic       cmd_wr,
    input  logic [1:0] cmd_field,
    output rst_scope_t req
);
    always_comb begin
        req = SCOPE_NONE;
        if (cmd_wr) begin
            req = scope_of_cmd(rst_cmd_e'(cmd_field));
        end
    end

    // R7
    always_comb begin
        sw_no_hw_chk: assert (!req.hw);
    end

endmodule

// File: rtl/stretch_timer.sv
module stretch_timer
    import rst_stretch_pkg::*;
#(
    parameter int STRETCH_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_low,
    input  rst_scope_t req,
    output rst_scope_t scope,
    output logic       active
);
    localparam int CNT_W = $clog2(STRETCH_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STRETCH_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    rst_scope_t       scope_q, scope_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             active_q, active_n;
    logic             any_req;

    assign any_req = scope_any(req);

    always_comb begin
        scope_n  = scope_q;
        cnt_n    = cnt_q;
        active_n = active_q;
        if (bus_low) begin
            scope_n  = SCOPE_HW;
            cnt_n    = CNT_LOAD;
            active_n = 1'b1;
        end else if (any_req) begin
            scope_n  = scope_merge(scope_q, req);
            cnt_n    = CNT_LOAD;
            active_n = 1'b1;
        end else if (active_q) begin
            if (cnt_q == CNT_LAST) begin
                scope_n  = SCOPE_NONE;
                cnt_n    = '0;
                active_n = 1'b0;
            end else begin
                cnt_n = cnt_q - CNT_LAST;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scope_q  <= SCOPE_NONE;
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else begin
            scope_q  <= scope_n;
            cnt_q    <= cnt_n;
            active_q <= active_n;
        end
    end

    assign scope  = scope_q;
    assign active = active_q;

    // R1
    hw_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bus_low |=> (scope_q.hw && scope_q.full && active_q));

    // R9
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (any_req && !bus_low) |=> (active_q && cnt_q == CNT_LOAD));

    // R10
    full_covers_chk: assert property (@(posedge clk) disable iff (rst)
        scope_q.full |-> (scope_q.a && scope_q.b));

    // R8
    hw_origin_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scope_q.hw) |-> $past(bus_low));

    // R4
    block_cover_chk: assert property (@(posedge clk) disable iff (rst)
        scope_any(scope_q) |-> active_q);

    // R2
    no_early_end_chk: assert property (@(posedge clk) disable iff (rst)
        (active_q && cnt_q > CNT_LAST) |=> active_q);

endmodule

// File: rtl/reset_stretch_ctrl.sv
module reset_stretch_ctrl
    import rst_stretch_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int STRETCH_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic       cmd_wr,
    input  logic [1:0] cmd_field,
    output logic       glb_rst,
    output logic       chan_a_rst,
    output logic       chan_b_rst,
    output logic       hw_rst,
    output logic       access_block
);
    logic       bus_low;
    rst_scope_t req;
    rst_scope_t scope;
    logic       active;

    strobe_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .bus_low (bus_low)
    );

    cmd_decode i_dec (
        .cmd_wr    (cmd_wr),
        .cmd_field (cmd_field),
        .req       (req)
    );

    stretch_timer #(.STRETCH_CYCLES(STRETCH_CYCLES)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .bus_low (bus_low),
        .req     (req),
        .scope   (scope),
        .active  (active)
    );

    assign glb_rst      = scope.full;
    assign chan_a_rst   = scope.a;
    assign chan_b_rst   = scope.b;
    assign hw_rst       = scope.hw;
    assign access_block = active;

    // R12
    clear_after_rst_chk: assert property (@(posedge clk)
        $past(rst) |-> !(glb_rst || chan_a_rst || chan_b_rst || hw_rst || access_block));

endmodule

// File: tb/test_reset_stretch_ctrl.sv
module test_reset_stretch_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic       rd_n, wr_n, cmd_wr;
    logic [1:0] cmd_field;
    logic       glb_rst, chan_a_rst, chan_b_rst, hw_rst, access_block;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // output vector: {glb, a, b, hw, block}
    localparam logic [4:0] V_IDLE = 5'b00000;
    localparam logic [4:0] V_HW   = 5'b11111;
    localparam logic [4:0] V_SWF  = 5'b11101;
    localparam logic [4:0] V_A    = 5'b01001;
    localparam logic [4:0] V_B    = 5'b00101;
    localparam logic [4:0] V_AB   = 5'b01101;

    always #4 clk = ~clk;

    reset_stretch_ctrl i_reset_stretch_ctrl (
        .clk(clk), .rst(rst), .rd_n(rd_n), .wr_n(wr_n),
        .cmd_wr(cmd_wr), .cmd_field(cmd_field),
        .glb_rst(glb_rst), .chan_a_rst(chan_a_rst), .chan_b_rst(chan_b_rst),
        .hw_rst(hw_rst), .access_block(access_block)
    );

    function automatic logic [4:0] outs();
        return {glb_rst, chan_a_rst, chan_b_rst, hw_rst, access_block};
    endfunction

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [4:0] exp);
        n_tests++;
        if (outs() !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs {glb,a,b,hw,blk} = %b expected %b", req, outs(), exp);
        end
    endtask

    task automatic send_cmd(logic [1:0] code);
        cmd_wr = 1'b1; cmd_field = code;
        step();
        cmd_wr = 1'b0; cmd_field = 2'b00;
    endtask

    // after the loading edge was already sampled: 3 more high, then low
    task automatic expect_tail(string req, logic [4:0] exp);
        for (int i = 0; i < 3; i++) begin
            step();
            check(req, exp);
        end
        step();
        check(req, V_IDLE);
    endtask

    task automatic do_reset();
        rst = 1'b1; rd_n = 1'b1; wr_n = 1'b1; cmd_wr = 1'b0; cmd_field = 2'b00;
        step(2);
        rst = 1'b0;
        step();
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R12 reset state", V_IDLE);
    endtask

    task automatic t_hw_reset();
        rd_n = 1'b0; wr_n = 1'b0;
        step(2);
        check("R1 not before sync", V_IDLE);
        step();
        check("R1 hw asserted", V_HW);
        step(4);
        check("R1 hw held", V_HW);
        rd_n = 1'b1; wr_n = 1'b1;
        for (int i = 1; i <= 5; i++) begin
            step();
            check("R2 stretch after release", V_HW);
        end
        step();
        check("R2 released on 6th edge", V_IDLE);
    endtask

    task automatic t_single_strobe();
        rd_n = 1'b0;
        step(6);
        check("R3 read strobe alone", V_IDLE);
        rd_n = 1'b1; wr_n = 1'b0;
        step(6);
        check("R3 write strobe alone", V_IDLE);
        wr_n = 1'b1;
        step(2);
    endtask

    task automatic t_channel(logic [1:0] code, logic [4:0] exp, string req);
        send_cmd(code);
        check(req, exp);
        expect_tail(req, exp);
    endtask

    task automatic t_noop();
        send_cmd(2'b00);
        check("R13 code 00", V_IDLE);
        step(2);
        check("R13 code 00 later", V_IDLE);
    endtask

    task automatic t_restart();
        send_cmd(2'b01);
        check("R9 B first", V_B);
        step(2);
        check("R9 B mid", V_B);
        send_cmd(2'b01);
        check("R9 B reloaded", V_B);
        expect_tail("R9 restart tail", V_B);
    endtask

    task automatic t_widen();
        send_cmd(2'b01);
        step();
        send_cmd(2'b10);
        check("R10 A merged into B", V_AB);
        expect_tail("R10 A+B tail", V_AB);
        send_cmd(2'b10);
        step();
        send_cmd(2'b11);
        check("R10 widen to full", V_SWF);
        expect_tail("R10 full tail", V_SWF);
    endtask

    task automatic t_coincident();
        rd_n = 1'b0; wr_n = 1'b0;
        step(2);
        cmd_wr = 1'b1; cmd_field = 2'b10;
        step();
        cmd_wr = 1'b0; cmd_field = 2'b00;
        check("R11 hardware wins", V_HW);
        rd_n = 1'b1; wr_n = 1'b1;
        step(5);
        check("R11 stretch kept", V_HW);
        step();
        check("R11 released", V_IDLE);
    endtask

    task automatic t_mid_rst();
        send_cmd(2'b11);
        check("R7 before rst", V_SWF);
        rst = 1'b1;
        step();
        rst = 1'b0;
        check("R12 rst clears stretch", V_IDLE);
        step();
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_hw_reset();
        t_single_strobe();
        t_channel(2'b01, V_B, "R5 R6 channel B");
        t_channel(2'b10, V_A, "R5 R6 channel A");
        t_channel(2'b11, V_SWF, "R7 R8 full software");
        t_noop();
        t_restart();
        t_widen();
        t_coincident();
        t_mid_rst();
        check("R4 idle at end", V_IDLE);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule